// File: doc/BRIEF.md
# I2C Clock Phase Generator with Independent High and Low Lengths

This block produces the serial clock for an I2C controller. A 32-bit divider word carries two 16-bit phase lengths: the upper half sets the released (high) phase and the lower half sets the driven-low phase. Each phase is counted in units of eight system clocks, and each field value implies one more unit than it states. A low phase therefore lasts (low_div + 1) x 8 cycles and a high phase lasts (high_div + 1) x 8 cycles. The clock rate is clk / (8 x (high_div + 1 + low_div + 1)). With separate lengths, software can meet the bus minimums: at least 1.3 us low and 0.6 us high in fast mode, and at least 4.7 us low and 4.0 us high in standard mode.

The output is open-drain style. `scl_pull_low` asks the pad to pull the line low, and when it is 0 the line is released. During the high phase the sampled line level `scl_sense` gates the count. A target that holds the line low stretches the high phase by exactly the number of cycles it holds. The divider word is captured only at the start of each low phase, so a period in progress keeps its lengths. Single-cycle strobes mark the first cycle of each low phase (data launch) and of each high phase (data sample).

START/STOP sequencing, data shifting and arbitration are the job of the surrounding controller. This block has no streamed data, so every pin is a plain control or status signal.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, and whenever the block is idle, `scl_pull_low`, `in_high_phase`, `launch_stb` and `sample_stb` are all 0.
- R2: A low phase lasts exactly (low_div + 1) x 8 clock cycles, measured from its `launch_stb` cycle to the next `sample_stb` cycle.
- R3: With `scl_sense` at 1, a high phase lasts exactly (high_div + 1) x 8 cycles, measured from its `sample_stb` cycle to the next `launch_stb` cycle.
- R4: `div_word[31:16]` is high_div and `div_word[15:0]` is low_div.
- R5: If the block is idle and `run` is sampled 1 at a clock edge, a low phase begins in the cycle after that edge, and `launch_stb` is 1 in that cycle.
- R6: `launch_stb` is 1 only in the first cycle of a low phase and `sample_stb` only in the first cycle of a high phase. The two are never 1 in the same cycle.
- R7: At each clock edge of a high phase where `scl_sense` is sampled 0, the count does not advance. The high phase grows by exactly that many cycles, and the line stays released.
- R8: `div_word` is captured at the edge that starts a low phase. The captured value sets that low phase and the high phase after it. A change at any other time has no effect until the next low phase starts.
- R9: When `run` is sampled 0, the block is idle in the next cycle, with the line released and no strobe.
- R10: `in_high_phase` is 1 exactly during high phases, and `scl_pull_low` is 1 exactly during low phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enable: 1 generates clock periods, 0 returns to idle |
| div_word | input | 32 | high_div in [31:16], low_div in [15:0] |
| scl_sense | input | 1 | Sampled bus clock level, used for stretch detection |
| scl_pull_low | output | 1 | 1 = pull the line low, 0 = release it |
| in_high_phase | output | 1 | 1 during a high phase |
| launch_stb | output | 1 | One-cycle pulse at the first cycle of a low phase |
| sample_stb | output | 1 | One-cycle pulse at the first cycle of a high phase |

## Verification
Two events can share a clock edge: the edge that ends a high phase and starts a low phase is also the edge that captures the divider word. The bench changes `div_word` in the cycle just before that boundary edge and expects the new lengths from that period on. It also changes the word in the middle of a low phase and expects the period already running to keep its old lengths. A scoreboard predicts the exact cycle of every launch and sample strobe, including the extra cycles added when the bench holds `scl_sense` low during a high phase, and reports any strobe that is early, late or unexpected.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } scl_state_e;
endpackage

// File: rtl/scl_tick_prescaler.sv
// Counts system clocks inside one phase unit; wraps every 2**LOG2 advances.
module scl_tick_prescaler #(
  parameter int LOG2 = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            adv,
  output logic [LOG2-1:0] cnt,
  output logic            last
);
  assign last = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_unit_counter.sv
// Counts whole units of a phase and flags the final one.
module scl_unit_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         at_lim
);
  assign at_lim = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2*DIV_W-1:0] div_word,
  input  logic             scl_sense,
  output logic             scl_pull_low,
  output logic             in_high_phase,
  output logic             launch_stb,
  output logic             sample_stb
);
  localparam int WORD_W = 2 * DIV_W;

  scl_state_e st_q, st_nxt;
  logic [DIV_W-1:0] hi_len_q, lo_len_q, cur_lim;
  logic [PRE_LOG2-1:0] pre_cnt;
  logic [DIV_W-1:0]    unit_cnt;
  logic pre_last, at_lim, adv, done, load, clear;

  assign adv     = (st_q == ST_LOW) || ((st_q == ST_HIGH) && scl_sense);
  assign cur_lim = (st_q == ST_HIGH) ? hi_len_q : lo_len_q;
  assign done    = adv && pre_last && at_lim;

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE: if (run) st_nxt = ST_LOW;
      ST_LOW:  if (!run) st_nxt = ST_IDLE; else if (done) st_nxt = ST_HIGH;
      ST_HIGH: if (!run) st_nxt = ST_IDLE; else if (done) st_nxt = ST_LOW;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign load  = (st_nxt == ST_LOW) && (st_q != ST_LOW);
  assign clear = (st_nxt != st_q) || (st_q == ST_IDLE);

  scl_tick_prescaler #(.LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(clear), .adv(adv),
    .cnt(pre_cnt), .last(pre_last)
  );

  scl_unit_counter #(.W(DIV_W)) u_unit (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(adv && pre_last),
    .lim(cur_lim), .cnt(unit_cnt), .at_lim(at_lim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      hi_len_q   <= '0;
      lo_len_q   <= '0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      launch_stb <= (st_nxt == ST_LOW)  && (st_q != ST_LOW);
      sample_stb <= (st_nxt == ST_HIGH) && (st_q != ST_HIGH);
      if (load) begin
        hi_len_q <= div_word[WORD_W-1:DIV_W];
        lo_len_q <= div_word[DIV_W-1:0];
      end
    end
  end

  assign scl_pull_low  = (st_q == ST_LOW);
  assign in_high_phase = (st_q == ST_HIGH);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_stb && sample_stb));

  // R5
  launch_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> launch_stb);

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high_phase && !scl_sense && run) |=> ($stable(pre_cnt) && $stable(unit_cnt) && in_high_phase));

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !launch_stb) |-> ($stable(hi_len_q) && $stable(lo_len_q)));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_pull_low && !in_high_phase && !launch_stb && !sample_stb));
endmodule

// File: tb/test_scl_phase_gen.sv
module test_scl_phase_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [31:0] div_word = '0;
  logic scl_sense = 1'b1;
  logic scl_pull_low, in_high_phase, launch_stb, sample_stb;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct { int kind; int at; string tag; } evt_t;  // kind 0 = launch, 1 = sample
  evt_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_phase_gen i_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .div_word(div_word),
    .scl_sense(scl_sense), .scl_pull_low(scl_pull_low),
    .in_high_phase(in_high_phase), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic push(input int kind, input int at, input string tag);
    evt_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic start_run(output int k);
    @(negedge clk);
    run = 1'b1;
    k = cyc + 1;
  endtask

  task automatic stop_and_check(input int c, input string tag);
    wait_until(c);
    run = 1'b0;
    wait_until(c + 2);
    chk(!scl_pull_low && !in_high_phase, tag, {scl_pull_low, in_high_phase}, 0);
    wait_until(c + 12);
    chk(exp_q.size() == 0, {tag, " pending strobes"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: pops predicted strobes and compares
  always @(negedge clk) begin
    if (rst_n && (launch_stb || sample_stb)) begin
      if (launch_stb && sample_stb) chk(0, "R6 both strobes", 1, 0);
      else if (exp_q.size() == 0) chk(0, "R6 unexpected strobe", int'(sample_stb), -1);
      else begin
        evt_t e;
        e = exp_q.pop_front();
        chk(e.kind == int'(sample_stb), {e.tag, " strobe kind"}, int'(sample_stb), e.kind);
        chk(e.at == cyc, {e.tag, " strobe cycle"}, cyc, e.at);
      end
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({scl_pull_low, in_high_phase, launch_stb, sample_stb} == 4'b0, "R1 reset",
        {scl_pull_low, in_high_phase, launch_stb, sample_stb}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_pull_low && !launch_stb, "R1 idle", scl_pull_low, 0);

    // R2 R3 R4 R5: high_div=1, low_div=2 -> low 24, high 16
    div_word = {16'd1, 16'd2};
    start_run(k);
    push(0, k, "R5"); push(1, k+24, "R2"); push(0, k+40, "R3");
    push(1, k+64, "R4"); push(0, k+80, "R4");
    wait_until(k+10);
    chk(scl_pull_low && !in_high_phase, "R10 low phase", {scl_pull_low, in_high_phase}, 2);
    wait_until(k+30);
    chk(!scl_pull_low && in_high_phase, "R10 high phase", {scl_pull_low, in_high_phase}, 1);
    stop_and_check(k+90, "R9 stop in low");

    // minimum lengths: both fields zero -> 8 and 8
    div_word = 32'd0;
    start_run(k);
    push(0, k, "R5"); push(1, k+8, "R2 min"); push(0, k+16, "R3 min"); push(1, k+24, "R2 min");
    stop_and_check(k+28, "R9 stop in high");

    // R7 stretch: high_div=2 (24), low_div=1 (16), hold low 10 edges
    div_word = {16'd2, 16'd1};
    start_run(k);
    push(0, k, "R5"); push(1, k+16, "R2"); push(0, k+50, "R7"); push(1, k+66, "R7");
    wait_until(k+16);
    scl_sense = 1'b0;
    wait_until(k+20);
    chk(!scl_pull_low && in_high_phase, "R7 released while held", {scl_pull_low, in_high_phase}, 1);
    wait_until(k+26);
    scl_sense = 1'b1;
    stop_and_check(k+70, "R9 after stretch");

    // R8 capture point
    div_word = {16'd1, 16'd2};
    start_run(k);
    push(0, k, "R5"); push(1, k+24, "R8 old low"); push(0, k+40, "R8 old high");
    push(1, k+72, "R8 new low"); push(0, k+80, "R8 new high"); push(1, k+88, "R8 boundary load");
    wait_until(k+5);
    div_word = {16'd0, 16'd3};
    wait_until(k+79);
    div_word = {16'd3, 16'd0};
    stop_and_check(k+100, "R9 after reload");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule